// File: doc/BRIEF.md
# ADC Scan Sequencer

This block is the digital controller that drives a successive-approximation converter core through a scan of its analog inputs. Software programs a first and a last channel, a sampling window length, a trigger source and a repeat mode through a small register port. After an accepted start, the controller visits each channel in ascending order. For each channel it holds a sampling phase for the programmed number of clocks. It then pulses a start to the converter core and waits for the core's done pulse.

Each returned result is latched together with its channel number. The latch raises a done flag and a one-cycle interrupt request. A result that replaces one still unread raises a sticky overwrite flag. A scan runs once, or it repeats until software drops the run bit or the enable bit. A start comes either from a register write or from a rising edge on one of three hardware trigger pins. Only the selected source is honoured.

Register map (2-bit address): 0 = CTRL, 1 = CHAN, 2 = DATA (read only), 3 = STATUS. CTRL bits: [0] enable, [1] run/start, [2] continuous, [4:3] trigger select, [6:5] sampling code. CHAN bits: [2:0] first channel, [10:8] last channel. DATA: [15:13] channel, [9:0] result. STATUS: [0] done flag, [1] overwrite flag.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, CTRL reads 0x0060 (sampling code 11, every other field 0), and STATUS and DATA read 0.
- R2: Each channel's sampling phase holds core_sample high for exactly 2*code+3 clock cycles (code = CTRL[6:5]: 3, 5, 7 or 9 cycles). A one-cycle core_start pulse follows it.
- R3: While the enable bit is 0, neither a software start nor any hardware trigger edge begins a scan.
- R4: With trigger select 00 and enable already 1, a CTRL write with enable=1, select=00 and run=1 begins a scan. CTRL bit 1 reads 1 while the scan is in progress.
- R5: Trigger select 01, 10 and 11 start a scan on a rising edge of trig_ext, trig_tmr_a and trig_tmr_b respectively. Edges on unselected pins are ignored. A software start is ignored unless select is 00.
- R6: Channels are converted in ascending order from the first to the last channel. When the last channel is below the first, only the first channel is converted.
- R7: In normal mode (CTRL[2]=0) the range is converted once. CTRL bit 1 then returns to 0 by itself.
- R8: In continuous mode the scan restarts at the first channel after the last one. Writing run=0 or enable=0 stops it, after which core_sample and core_start stay low.
- R9: Each result is stored in DATA as {channel[15:13], result[9:0]}, sets STATUS[0] and gives one irq pulse.
- R10: Reading DATA clears STATUS[0].
- R11: A result that arrives while STATUS[0] is set sets STATUS[1]. It stays set until a STATUS write with bit 1 = 1.
- R12: A trigger edge that arrives while a scan is running is ignored and does not add conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on DATA) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| trig_ext | input | 1 | External trigger pin, asynchronous |
| trig_tmr_a | input | 1 | Timer A trigger, asynchronous |
| trig_tmr_b | input | 1 | Timer B trigger, asynchronous |
| core_sample | output | 1 | High during the sampling phase |
| core_start | output | 1 | One-cycle start pulse to the converter core |
| core_chan | output | 3 | Channel being sampled or converted |
| core_done | input | 1 | One-cycle done pulse from the core |
| core_result | input | 10 | Conversion result, valid with core_done |
| irq | output | 1 | One-cycle interrupt request per stored result |

## Verification
The hardest states to reach are the stopping points of a continuous scan and a second trigger that lands mid-scan. Neither shows directly at the ports while it happens. The bench models the core as a fixed-latency stub and logs every core_start with its channel. It waits on that log until a chosen number of conversions has happened, then writes run=0 or enable=0. The order of the log and the frozen conversion count then expose any restart or stray conversion. The overwrite flag is reached by leaving DATA unread across a multi-channel scan. A table of channel ranges and sampling codes checks the window length, the channel order and the flag values of every scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_LAUNCH = 2'd2,
      ST_WAIT   = 2'd3
   } scan_state_e;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CHAN = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   localparam int B_EN   = 0;
   localparam int B_RUN  = 1;
   localparam int B_CONT = 2;
   localparam int B_TSEL = 3;
   localparam int B_SAMP = 5;
   localparam int CH_END_LSB = 8;

   localparam logic [1:0] TS_SW   = 2'b00;
   localparam logic [1:0] TS_EXT  = 2'b01;
   localparam logic [1:0] TS_TMRA = 2'b10;
   localparam logic [1:0] TS_TMRB = 2'b11;

endpackage

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
   parameter int N_SRC       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] hw_in,
   output logic [N_SRC-1:0] hw_rise
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (N_SRC >= 1) else $error("N_SRC must be at least 1");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [SYNC_STAGES:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-1:0], hw_in[i]};
      end
      assign hw_rise[i] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

      // R5
      rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hw_rise[i] |=> !hw_rise[i]);
   end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
#(
   parameter int CH_W   = 3,
   parameter int SAMP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              halt,
   input  logic              cont,
   input  logic [SAMP_W-1:0] samp_code,
   input  logic [CH_W-1:0]   ch_first,
   input  logic [CH_W-1:0]   ch_last,
   input  logic              core_done,
   output logic              sampling,
   output logic              core_start,
   output logic [CH_W-1:0]   chan,
   output logic              busy,
   output logic              res_we,
   output logic              scan_fin
);
   localparam int CNT_W = SAMP_W + 2;

   scan_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load;
   logic             last;

   // window of 2*code+3 cycles: counter runs load..0
   assign load       = CNT_W'({samp_code, 1'b0}) + CNT_W'(2);
   assign last       = (chan >= ch_last);
   assign sampling   = (state == ST_SAMPLE);
   assign core_start = (state == ST_LAUNCH);
   assign busy       = (state != ST_IDLE);
   assign res_we     = (state == ST_WAIT) && core_done && !halt;
   assign scan_fin   = res_we && last && !cont;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         chan  <= '0;
      end else if (state == ST_IDLE) begin
         if (go) begin
            state <= ST_SAMPLE;
            cnt   <= load;
            chan  <= ch_first;
         end
      end else if (halt) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_SAMPLE: begin
               if (cnt == '0) state <= ST_LAUNCH;
               else           cnt   <= cnt - CNT_W'(1);
            end
            ST_LAUNCH: state <= ST_WAIT;
            ST_WAIT: begin
               if (core_done) begin
                  if (!last) begin
                     chan  <= chan + CH_W'(1);
                     state <= ST_SAMPLE;
                     cnt   <= load;
                  end else if (cont) begin
                     chan  <= ch_first;
                     state <= ST_SAMPLE;
                     cnt   <= load;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8
   halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && halt) |=> !busy);
   // R2
   samp_to_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sampling) |-> (core_start || !busy));
   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
   parameter int RES_W  = 10,
   parameter int CH_W   = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RES_W-1:0]  res,
   input  logic [CH_W-1:0]   ch,
   input  logic              rd_clr,
   input  logic              owe_clr,
   output logic [DATA_W-1:0] data,
   output logic              adf,
   output logic              owe,
   output logic              irq
);
   initial begin
      assert (RES_W + CH_W <= DATA_W) else $error("result and channel do not fit DATA_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data <= '0;
         adf  <= 1'b0;
         owe  <= 1'b0;
         irq  <= 1'b0;
      end else begin
         irq <= we;
         if (we) begin
            data[RES_W-1:0]       <= res;
            data[DATA_W-1 -: CH_W] <= ch;
         end
         if (we)          adf <= 1'b1;
         else if (rd_clr) adf <= 1'b0;
         if (we && adf && !rd_clr) owe <= 1'b1;
         else if (owe_clr)         owe <= 1'b0;
      end
   end

   // R11
   owe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owe) |-> $past(adf));
   // R9
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> adf);
   // R10
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !we) |=> !adf);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int RES_W       = 10,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              trig_ext,
   input  logic              trig_tmr_a,
   input  logic              trig_tmr_b,
   output logic              core_sample,
   output logic              core_start,
   output logic [CH_W-1:0]   core_chan,
   input  logic              core_done,
   input  logic [RES_W-1:0]  core_result,
   output logic              irq
);
   localparam int SAMP_W = 2;
   localparam int N_HW   = 3;

   initial begin
      assert (NCH >= 2) else $error("NCH must be at least 2");
      assert (CH_END_LSB + CH_W <= DATA_W) else $error("channel fields do not fit DATA_W");
      assert (B_SAMP + SAMP_W <= DATA_W) else $error("control fields do not fit DATA_W");
   end

   logic              en_q, cont_q, adst_q;
   logic [1:0]        tsel_q;
   logic [SAMP_W-1:0] samp_q;
   logic [CH_W-1:0]   ch_first_q, ch_last_q;
   logic [N_HW-1:0]   hw_rise;
   logic              hw_hit, sw_go, hw_go, go, halt, busy;
   logic              res_we, scan_fin, ctrl_wr, rd_clr, owe_clr;
   logic [DATA_W-1:0] data_q;
   logic              adf, owe;
   logic              unused_wbits;

   assign unused_wbits = &{1'b0, reg_wdata};

   adc_trig_gate #(.N_SRC(N_HW), .SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n),
      .hw_in({trig_tmr_b, trig_tmr_a, trig_ext}),
      .hw_rise(hw_rise));

   always_comb begin
      unique case (tsel_q)
         TS_EXT:  hw_hit = hw_rise[0];
         TS_TMRA: hw_hit = hw_rise[1];
         TS_TMRB: hw_hit = hw_rise[2];
         default: hw_hit = 1'b0;
      endcase
   end

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign rd_clr  = reg_rd && (reg_addr == A_DATA);
   assign owe_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[1];
   assign sw_go   = ctrl_wr && reg_wdata[B_RUN] && reg_wdata[B_EN]
                    && (reg_wdata[B_TSEL +: 2] == TS_SW) && en_q && !busy;
   assign hw_go   = en_q && !busy && hw_hit;
   assign go      = sw_go || hw_go;
   assign halt    = !en_q || !adst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         cont_q     <= 1'b0;
         tsel_q     <= TS_SW;
         samp_q     <= '1;
         adst_q     <= 1'b0;
         ch_first_q <= '0;
         ch_last_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            en_q   <= reg_wdata[B_EN];
            cont_q <= reg_wdata[B_CONT];
            tsel_q <= reg_wdata[B_TSEL +: 2];
            samp_q <= reg_wdata[B_SAMP +: SAMP_W];
         end
         if (reg_wr && (reg_addr == A_CHAN)) begin
            ch_first_q <= reg_wdata[CH_W-1:0];
            ch_last_q  <= reg_wdata[CH_END_LSB +: CH_W];
         end
         if (go)
            adst_q <= 1'b1;
         else if ((ctrl_wr && !reg_wdata[B_RUN]) || !en_q || scan_fin)
            adst_q <= 1'b0;
      end
   end

   adc_scan_fsm #(.CH_W(CH_W), .SAMP_W(SAMP_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .cont(cont_q),
      .samp_code(samp_q), .ch_first(ch_first_q), .ch_last(ch_last_q),
      .core_done(core_done), .sampling(core_sample), .core_start(core_start),
      .chan(core_chan), .busy(busy), .res_we(res_we), .scan_fin(scan_fin));

   adc_result_reg #(.RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .we(res_we), .res(core_result), .ch(core_chan),
      .rd_clr(rd_clr), .owe_clr(owe_clr), .data(data_q), .adf(adf), .owe(owe),
      .irq(irq));

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL: begin
            reg_rdata[B_EN]             = en_q;
            reg_rdata[B_RUN]            = adst_q;
            reg_rdata[B_CONT]           = cont_q;
            reg_rdata[B_TSEL +: 2]      = tsel_q;
            reg_rdata[B_SAMP +: SAMP_W] = samp_q;
         end
         A_CHAN: begin
            reg_rdata[CH_W-1:0]          = ch_first_q;
            reg_rdata[CH_END_LSB +: CH_W] = ch_last_q;
         end
         A_DATA:  reg_rdata = data_q;
         default: reg_rdata[1:0] = {owe, adf};
      endcase
   end

   // R3
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en_q));
   // R7
   adst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !adst_q);
   // R12
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !halt && !core_done) |=> $stable(core_chan));
endmodule

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
   localparam int LAT = 4;
   localparam int EN = 1, RUN = 2, CONT = 4;
   localparam int NV = 5;
   // first, last, sampling code
   localparam int VEC [NV][3] = '{'{0,2,3}, '{3,3,0}, '{5,7,1}, '{2,6,2}, '{4,1,1}};

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic [2:0]  trig_v = 3'b000;
   logic        core_sample, core_start, irq;
   logic [2:0]  core_chan;
   logic        core_done = 1'b0;
   logic [9:0]  core_result = 10'd0;

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_irq = 0, bad_samp = 0, run = 0, exp_len = 9;
   int logv [0:1023];

   always #4 clk = ~clk;

   adc_scan_ctrl u_adc_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trig_ext(trig_v[0]), .trig_tmr_a(trig_v[1]), .trig_tmr_b(trig_v[2]),
      .core_sample(core_sample), .core_start(core_start), .core_chan(core_chan),
      .core_done(core_done), .core_result(core_result), .irq(irq));

   function automatic logic [9:0] model(input int ch);
      return 10'((ch * 97 + 13) % 1024);
   endfunction

   // converter core stub
   logic [3:0] lat_cnt = 4'd0;
   logic       pend = 1'b0;
   int         st_chan = 0;
   always @(posedge clk) begin
      core_done <= 1'b0;
      if (core_start) begin
         pend <= 1'b1; lat_cnt <= 4'(LAT); st_chan <= int'(core_chan);
      end else if (pend) begin
         if (lat_cnt == 4'd1) begin
            pend <= 1'b0; core_done <= 1'b1; core_result <= model(st_chan);
         end else lat_cnt <= lat_cnt - 4'd1;
      end
   end

   // monitor
   always @(posedge clk) begin
      if (rst_n) begin
         if (core_start) begin
            logv[n_start % 1024] = int'(core_chan);
            n_start++;
         end
         if (irq) n_irq++;
         if (core_sample) run++;
         else if (run != 0) begin
            if (run != exp_len) bad_samp++;
            run = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = 16'(d);
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 v = int'(reg_rdata);
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); trig_v[idx] = 1'b1;
      repeat (3) @(negedge clk);
      trig_v[idx] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_idle(input string rq);
      int v; bit done; done = 0;
      for (int i = 0; i < 3000 && !done; i++) begin
         rd(2'd0, v);
         if ((v & RUN) == 0) done = 1;
      end
      chk(done, rq, 1, 0);
   endtask

   task automatic wait_starts(input int target);
      for (int i = 0; i < 5000 && n_start < target; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int v, s, e, c, nexp, base, bbad, birq, lastc;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk(v == 'h60, "R1 ctrl", v, 'h60);
      rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 data", v, 0);
      chk(core_sample == 0 && core_start == 0 && irq == 0, "R1 outputs", 1, 0);

      // table of scans: R2 R4 R6 R7 R9 R10 R11
      for (int k = 0; k < NV; k++) begin
         s = VEC[k][0]; e = VEC[k][1]; c = VEC[k][2];
         exp_len = 2 * c + 3;
         nexp = (e >= s) ? e - s + 1 : 1;
         lastc = s + nexp - 1;
         base = n_start; bbad = bad_samp; birq = n_irq;
         wr(2'd1, s | (e << 8));
         wr(2'd0, EN | (c << 5));
         wr(2'd0, EN | RUN | (c << 5));
         rd(2'd0, v); chk((v & RUN) != 0, "R4 busy readback", v, EN | RUN | (c << 5));
         wait_idle("R7 scan end");
         rd(2'd0, v); chk(v == (EN | (c << 5)), "R7 run bit cleared", v, EN | (c << 5));
         chk(n_start - base == nexp, "R6 conversion count", n_start - base, nexp);
         for (int j = 0; j < nexp; j++)
            chk(logv[(base + j) % 1024] == s + j, "R6 order", logv[(base + j) % 1024], s + j);
         chk(bad_samp == bbad, "R2 sampling window", bad_samp - bbad, 0);
         chk(n_irq - birq == nexp, "R9 irq count", n_irq - birq, nexp);
         rd(2'd3, v); chk(v == (1 | ((nexp > 1) ? 2 : 0)), "R11 status", v, 1 | ((nexp > 1) ? 2 : 0));
         rd(2'd2, v); chk(v == ((lastc << 13) | int'(model(lastc))), "R9 data", v, (lastc << 13) | int'(model(lastc)));
         rd(2'd3, v); chk((v & 1) == 0, "R10 flag cleared", v, (nexp > 1) ? 2 : 0);
         wr(2'd3, 2);
      end

      // R3 enable gate
      base = n_start;
      wr(2'd1, 0);
      wr(2'd0, RUN | (3 << 5));
      repeat (20) @(negedge clk);
      chk(n_start == base, "R3 sw start while disabled", n_start - base, 0);
      rd(2'd0, v); chk((v & RUN) == 0, "R3 run bit", v, 3 << 5);
      wr(2'd0, (1 << 3) | (3 << 5));
      pulse(0);
      repeat (20) @(negedge clk);
      chk(n_start == base, "R3 hw edge while disabled", n_start - base, 0);

      // R5 trigger select
      wr(2'd0, EN | (2 << 3) | (3 << 5));
      pulse(2); pulse(0);
      repeat (20) @(negedge clk);
      chk(n_start == base, "R5 unselected pins", n_start - base, 0);
      wr(2'd0, EN | RUN | (2 << 3) | (3 << 5));
      repeat (20) @(negedge clk);
      chk(n_start == base, "R5 sw start with hw select", n_start - base, 0);
      wr(2'd0, EN | (2 << 3) | (3 << 5));
      pulse(1);
      wait_idle("R5 timer A scan");
      chk(n_start == base + 1, "R5 timer A", n_start - base, 1);
      wr(2'd0, EN | (3 << 3) | (3 << 5));
      pulse(2);
      wait_idle("R5 timer B scan");
      chk(n_start == base + 2, "R5 timer B", n_start - base, 2);

      // R12 trigger during a scan
      base = n_start;
      wr(2'd0, EN | (1 << 3) | (3 << 5));
      pulse(0); pulse(0);
      wait_idle("R12 scan end");
      chk(n_start == base + 1, "R12 extra trigger", n_start - base, 1);

      // R11 sticky until cleared, R10
      wr(2'd3, 2);
      rd(2'd2, v);
      wr(2'd1, 0 | (1 << 8));
      wr(2'd0, EN);
      wr(2'd0, EN | RUN);
      wait_idle("R11 scan end");
      wr(2'd3, 1);
      rd(2'd3, v); chk(v == 3, "R11 sticky", v, 3);
      wr(2'd3, 2);
      rd(2'd3, v); chk(v == 1, "R11 cleared", v, 1);
      rd(2'd2, v);
      rd(2'd3, v); chk(v == 0, "R10 read clears", v, 0);

      // R8 continuous, stopped by run=0
      base = n_start;
      wr(2'd1, 1 | (2 << 8));
      wr(2'd0, EN | CONT);
      wr(2'd0, EN | CONT | RUN);
      wait_starts(base + 5);
      wr(2'd0, EN | CONT);
      for (int j = 0; j < 5; j++)
         chk(logv[(base + j) % 1024] == 1 + (j % 2), "R8 repeat order", logv[(base + j) % 1024], 1 + (j % 2));
      rd(2'd0, v); chk((v & RUN) == 0, "R8 stop by run", v, EN | CONT);
      base = n_start;
      repeat (30) @(negedge clk);
      chk(n_start == base && core_sample == 0 && core_start == 0, "R8 idle after stop", n_start - base, 0);

      // R8 continuous, stopped by enable=0
      wr(2'd0, EN | CONT | RUN);
      wait_starts(base + 2);
      wr(2'd0, CONT);
      base = n_start;
      repeat (30) @(negedge clk);
      chk(n_start == base && core_sample == 0, "R8 stop by enable", n_start - base, 0);
      rd(2'd0, v); chk((v & RUN) == 0, "R8 run bit after disable", v, CONT);

      summary();
      $finish;
   end
endmodule